// File: doc/BRIEF.md
# Interval Timer with Periodic Reload

This block is a single down-counting event timer. It advances only on cycles where a one-cycle tick enable is high; the tick normally arrives once per microsecond from a shared prescaler. Software sets the timer up with one write to a trigger word. That word carries an arm bit, a repeat bit and a 29-bit count. The count uses an n+1 encoding: a value V expires on the (V+1)-th tick, so a value of 0 expires on the first tick.

On expiry the block sets a pending flag, which drives a level interrupt. In repeat mode the counter reloads the programmed value and keeps running, so events come at a fixed rate. In single mode the arm bit clears itself and the counter stops at zero. The pending flag stays set until software writes a word with bit 30 set to the control offset. A second word at that same offset reports the pending flag and the live count.

Top module: `evt_timer`

## Requirements
- R1: After reset the interrupt output is low, and reads at offset 0x0 and offset 0x4 both return zero.
- R2: A write at offset 0x0 stores bit 31 as the arm bit, bit 30 as the repeat bit and bits 28:0 as the count value. A read at 0x0 returns them in the same positions, with bit 29 reading as zero.
- R3: When armed with value V, the interrupt rises right after the (V+1)-th tick and not before. V = 0 expires on the first tick.
- R4: The counter changes only on a cycle where the tick is high. Between ticks the count read at 0x4 stays the same.
- R5: In single mode (bit 30 clear), expiry clears the arm bit. Further ticks raise no new event and leave the count at zero.
- R6: In repeat mode (bit 30 set), expiry reloads the stored value. The arm bit stays set and events recur every V+1 ticks.
- R7: Writing zero to offset 0x0 disarms the timer. After that, ticks raise no event and do not change the count.
- R8: The interrupt stays high until a write at offset 0x4 with bit 30 set. A write at 0x4 with bit 30 clear leaves it unchanged.
- R9: When an expiry and a clear write fall in the same cycle, the pending flag ends up set.
- R10: A write at offset 0x0 loads the counter at once from the new value, even while the timer runs. A tick in the same cycle is ignored.
- R11: A read at offset 0x4 returns the pending flag in bit 30 and the live count in bits 28:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable (1 MHz rate) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt, the pending flag |

## Verification
The bench probes the n+1 boundary with V = 0 and V = 3. A counter that expired on V ticks, or on V+2, would raise the interrupt one tick early or late. It runs single mode past expiry to catch an arm bit that fails to clear, which would show up as repeated events. It runs repeat mode over two periods to catch a reload that loses a tick. It drives a clear in the same cycle as an expiry, where a clear that wins would drop an event. It drives a trigger write in the same cycle as a tick, where a design that decremented after the load would show the count one lower than written.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    parameter int CNT_W = 29;

    typedef struct packed {
        logic             armed;
        logic             repeat_m;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        logic             pend;
    } tmr_state_t;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int ARM_BIT  = 31,
    parameter int RPT_BIT  = 30,
    parameter int CLR_BIT  = 30,
    parameter int PEND_BIT = 30,
    parameter int TRIG_OFS = 0,
    parameter int CTRL_OFS = 4
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  tmr_state_t        st_i,
    output logic              load_o,
    output logic              load_arm_o,
    output logic              load_rpt_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic hit_trig;
    logic hit_ctrl;
    logic unused_wbits;

    always_comb begin
        hit_trig   = (addr_i == TRIG_A);
        hit_ctrl   = (addr_i == CTRL_A);
        load_o     = wr_i & hit_trig;
        clr_o      = wr_i & hit_ctrl & wdata_i[CLR_BIT];
        load_arm_o = wdata_i[ARM_BIT];
        load_rpt_o = wdata_i[RPT_BIT];
        load_val_o = wdata_i[CNT_W-1:0];
    end

    assign unused_wbits = ^wdata_i;

    always_comb begin
        rdata_o = '0;
        if (hit_trig) begin
            rdata_o[CNT_W-1:0] = st_i.reload;
            rdata_o[ARM_BIT]   = st_i.armed;
            rdata_o[RPT_BIT]   = st_i.repeat_m;
        end else if (hit_ctrl) begin
            rdata_o[CNT_W-1:0] = st_i.count;
            rdata_o[PEND_BIT]  = st_i.pend;
        end
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             load_arm_i,
    input  logic             load_rpt_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    output tmr_state_t       st_o
);

    tmr_state_t st_d, st_q;
    logic       expire;
    logic       at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.count == '0);
        expire  = st_q.armed & tick_i & at_zero & ~load_i;
        if (load_i) begin
            st_d.armed    = load_arm_i;
            st_d.repeat_m = load_rpt_i;
            st_d.reload   = load_val_i;
            st_d.count    = load_val_i;
        end else if (st_q.armed && tick_i) begin
            if (at_zero) begin
                if (st_q.repeat_m) st_d.count = st_q.reload;
                else               st_d.armed = 1'b0;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
        if (clr_i)  st_d.pend = 1'b0;
        if (expire) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    // R3
    rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(tick_i & st_q.armed & (st_q.count == '0)));

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(st_q.count));

    // R5
    single_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st_q.repeat_m) |=> !st_q.armed);

    // R6
    repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.repeat_m) |=> (st_q.armed && st_q.count == st_q.reload));

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_i) |=> st_q.pend);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && clr_i) |=> st_q.pend);

    // R10
    load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.count == $past(load_val_i)));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    tmr_state_t       st;
    logic             load;
    logic             load_arm;
    logic             load_rpt;
    logic [CNT_W-1:0] load_val;
    logic             clr;

    evt_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .st_i       (st),
        .load_o     (load),
        .load_arm_o (load_arm),
        .load_rpt_o (load_rpt),
        .load_val_o (load_val),
        .clr_o      (clr),
        .rdata_o    (bus_rdata_o)
    );

    evt_timer_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (load),
        .load_arm_i (load_arm),
        .load_rpt_i (load_rpt),
        .load_val_i (load_val),
        .clr_i      (clr),
        .st_o       (st)
    );

    assign irq_o = st.pend;

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    evt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
        tick = t; wr = w; addr = a; wdata = d;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(4'h0, v); check("R1 trig", v, 32'h0);
        rd(4'h4, v); check("R1 stat", v, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        step(1'b0, 1'b1, 4'h0, 32'hE000_0005);
        rd(4'h0, v); check("R2 readback", v, 32'hC000_0005);
        rd(4'h4, v); check("R11 status count", v, 32'h0000_0005);
        step(1'b0, 1'b1, 4'h0, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        step(1'b0, 1'b1, 4'h0, 32'h8000_0003);
        ticks(3);
        check("R3 early", {31'b0, irq}, 32'h0);
        rd(4'h4, v); check("R3 count at zero", v, 32'h0);
        ticks(1);
        check("R3 fire", {31'b0, irq}, 32'h1);
        rd(4'h0, v); check("R5 disarmed", v, 32'h0000_0003);
        rd(4'h4, v); check("R11 status pend", v, 32'h4000_0000);
        step(1'b0, 1'b1, 4'h4, 32'h0);
        check("R8 no-clear write", {31'b0, irq}, 32'h1);
        step(1'b0, 1'b1, 4'h4, 32'h4000_0000);
        check("R8 cleared", {31'b0, irq}, 32'h0);
        ticks(6);
        check("R5 no refire", {31'b0, irq}, 32'h0);
        rd(4'h4, v); check("R5 count stays", v, 32'h0);
    endtask

    task automatic t_zero();
        step(1'b0, 1'b1, 4'h0, 32'h8000_0000);
        ticks(1);
        check("R3 V=0 one tick", {31'b0, irq}, 32'h1);
        step(1'b0, 1'b1, 4'h4, 32'h4000_0000);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        step(1'b0, 1'b1, 4'h0, 32'h8000_0007);
        ticks(2);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 4'h0, 32'h0);
        rd(4'h4, v); check("R4 hold without tick", v, 32'h0000_0005);
        step(1'b0, 1'b1, 4'h0, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        step(1'b0, 1'b1, 4'h0, 32'hC000_0002);
        ticks(3);
        check("R6 first event", {31'b0, irq}, 32'h1);
        rd(4'h4, v); check("R6 reloaded", v, 32'h4000_0002);
        step(1'b0, 1'b1, 4'h4, 32'h4000_0000);
        ticks(2);
        check("R6 between events", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R6 second event", {31'b0, irq}, 32'h1);
        rd(4'h0, v); check("R6 still armed", v, 32'hC000_0002);
        step(1'b0, 1'b1, 4'h4, 32'h4000_0000);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        step(1'b0, 1'b1, 4'h0, 32'hC000_0001);
        ticks(1);
        step(1'b0, 1'b1, 4'h0, 32'h0);
        ticks(5);
        check("R7 no event", {31'b0, irq}, 32'h0);
        rd(4'h4, v); check("R7 count idle", v, 32'h0);
    endtask

    task automatic t_collide();
        step(1'b0, 1'b1, 4'h0, 32'hC000_0000);
        ticks(1);
        check("R9 prefire", {31'b0, irq}, 32'h1);
        step(1'b1, 1'b1, 4'h4, 32'h4000_0000);
        check("R9 set wins", {31'b0, irq}, 32'h1);
        step(1'b0, 1'b1, 4'h0, 32'h0);
        step(1'b0, 1'b1, 4'h4, 32'h4000_0000);
        check("R9 then clears", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_rewrite();
        logic [31:0] v;
        step(1'b0, 1'b1, 4'h0, 32'h8000_000A);
        ticks(3);
        step(1'b0, 1'b1, 4'h0, 32'h8000_0001);
        rd(4'h4, v); check("R10 reload now", v, 32'h0000_0001);
        ticks(1);
        check("R10 not yet", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R10 fires new", {31'b0, irq}, 32'h1);
        step(1'b0, 1'b1, 4'h4, 32'h4000_0000);
        step(1'b0, 1'b1, 4'h0, 32'h8000_000A);
        step(1'b1, 1'b1, 4'h0, 32'h8000_0004);
        rd(4'h4, v); check("R10 tick ignored", v, 32'h0000_0004);
        step(1'b0, 1'b1, 4'h0, 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_single();
        t_zero();
        t_idle();
        t_periodic();
        t_disable();
        t_collide();
        t_rewrite();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule